// File: doc/BRIEF.md
# Cascadable Configuration Stream Sequencer

This block reads a stored configuration image out of a small on-chip byte array and streams it to a loading device. It steps an internal read position on each qualified clock edge and presents the current data in one of two widths. In serial mode, one bit leaves per clock, with the most significant bit of each byte first. In wide mode, one whole byte leaves per clock. Each data pin has its own output-enable line, so a pad ring can put the pins in high impedance when the block is not driving.

Two active-low controls qualify the stream. The chip-select input puts the block in standby. The combined enable/reset input holds the read position at the start of the image. When the read position passes the last byte, the block stops driving data and asserts a hand-off output, which feeds the chip-select of the next sequencer in a cascade. The readout width is latched while the enable/reset input is low. The last byte address and the hand-off polarity are elaboration parameters. A write port fills the byte array before use.

Top module: `cfg_stream_seq`

## Requirements
- R1: On a rising edge the read position advances only when `sel_n` is 0, `en_rst_n` is 1 and the end of the image has not yet been passed.
- R2: A rising edge with `en_rst_n` at 0 returns the read position to byte 0, bit 0 and clears the passed-end state. While `en_rst_n` is 0, `dq_oe` and `dq_o` are all zero.
- R3: While `sel_n` is 1 the block is in standby: `dq_oe` and `dq_o` are all zero, and the read position is unchanged on every edge.
- R4: The hand-off output is active only when `sel_n` is 0, `en_rst_n` is 1 and the end of the image has been passed. After that, it follows `sel_n` for as long as `en_rst_n` stays 1.
- R5: While `en_rst_n` is 0 the hand-off output is inactive. After release it stays inactive until the end of the image has been passed again.
- R6: The edge that advances from the last position (byte `LAST_BYTE`, with bit 7 in serial mode) sets the passed-end state. From then on the position is frozen and `dq_oe` is all zero.
- R7: In serial mode (latched mode bit 0), `dq_oe` is 8'b0000_0001. `dq_o[0]` carries bit 7−k of the current byte, where k counts 0..7, and the other pins are 0. After k=7 the next edge moves to bit 7 of the next byte.
- R8: In wide mode (latched mode bit 1), `dq_oe` is 8'hFF and `dq_o` carries the current byte. The next byte appears after the rising edge that advances the position, so the receiver can capture it on the following edge.
- R9: The mode bit `wide_i` is captured on every rising edge where `en_rst_n` is 0. Changes while `en_rst_n` is 1 have no effect on the output.
- R10: With `HANDOFF_HIGH`=0 the hand-off output is 0 when active and 1 when inactive. With `HANDOFF_HIGH`=1 it is 1 when active and 0 when inactive.
- R11: A rising edge with `ld_en` at 1 writes `ld_data` into byte `ld_addr` of the array. The value is then streamed when that byte is read out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stream clock, rising edge active |
| sel_n | input | 1 | Active-low chip select; 1 = standby |
| en_rst_n | input | 1 | Active-low combined output enable / synchronous reset |
| wide_i | input | 1 | Readout width request (0 serial, 1 byte), latched during reset |
| ld_en | input | 1 | Array write strobe |
| ld_addr | input | AW | Array write byte address |
| ld_data | input | 8 | Array write data |
| dq_o | output | 8 | Data pins (serial uses bit 0) |
| dq_oe | output | 8 | Per-pin output enable, 1 = driving |
| handoff_o | output | 1 | Hand-off to next device, polarity set by HANDOFF_HIGH |

## Verification
The clocked assertions assume that `en_rst_n` has been held low for at least one edge before streaming starts. Until that first edge the read position is undefined. They also assume that the write port only changes bytes the stream is not reading at that moment. The bench holds `en_rst_n` low across the first edges and does all array writes during that reset window. It then drives select, enable/reset and the mode request from a seeded `$urandom` mix, with directed runs across the image end, a reset in the middle of the stream and mode changes outside reset. A second instance with the opposite hand-off polarity shares every input.

// File: rtl/cfg_seq_pkg.sv
// Package: shared constants and the readout-width type of the sequencer.
// Assumes: bytes are 8 bits; serial order is most significant bit first.
package cfg_seq_pkg;
    localparam int BYTE_W    = 8;
    localparam int BIT_IDX_W = 3;

    typedef enum logic {
        RD_SERIAL = 1'b0,
        RD_WIDE   = 1'b1
    } rd_mode_e;
endpackage

// File: rtl/cfg_seq_store.sv
// Module: byte array holding the image. Synchronous write, combinational read.
// Assumes: the writer does not change a byte in the cycle it is being read.
module cfg_seq_store #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    localparam int SLOTS = 1 << AW;

    logic [7:0] mem_q [SLOTS];

    // Purpose: write one byte per qualified edge.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // Purpose: present the addressed byte to the output stage.
    always_comb begin
        rd_data = mem_q[rd_addr];
    end
endmodule

// File: rtl/cfg_seq_counter.sv
// Module: read position (byte address + bit index), passed-end flag and the
// latched readout width. Synchronous active-low reset via en_rst_n.
// Assumes: LAST_BYTE fits in AW bits.
module cfg_seq_counter
    import cfg_seq_pkg::*;
#(
    parameter int AW        = 4,
    parameter int LAST_BYTE = 15
) (
    input  logic                 clk,
    input  logic                 sel_n,
    input  logic                 en_rst_n,
    input  logic                 wide_i,
    output logic [AW-1:0]        byte_q,
    output logic [BIT_IDX_W-1:0] bit_q,
    output logic                 done_q,
    output rd_mode_e             mode_q
);
    localparam logic [AW-1:0]        LAST_A  = AW'(LAST_BYTE);
    localparam logic [BIT_IDX_W-1:0] LAST_BI = '1;

    logic step;
    logic byte_end;
    logic at_last;

    // Purpose: decide whether this edge advances and where the position wraps.
    always_comb begin
        step     = !sel_n && en_rst_n && !done_q;
        byte_end = (mode_q == RD_WIDE) || (bit_q == LAST_BI);
        at_last  = byte_end && (byte_q == LAST_A);
    end

    // Purpose: update position, end flag and latched mode.
    always_ff @(posedge clk) begin
        if (!en_rst_n) begin
            byte_q <= '0;
            bit_q  <= '0;
            done_q <= 1'b0;
            mode_q <= rd_mode_e'(wide_i);
        end else if (step) begin
            if (at_last) begin
                done_q <= 1'b1;
            end else if (byte_end) begin
                byte_q <= byte_q + 1'b1;
                bit_q  <= '0;
            end else begin
                bit_q  <= bit_q + 1'b1;
            end
        end
    end

    // R2
    // Reset edge must return the position to the start.
    pos_reset_chk: assert property (@(posedge clk)
        !en_rst_n |=> (byte_q == '0 && bit_q == '0 && !done_q));

    // R3
    // Standby edge leaves the position untouched.
    standby_hold_chk: assert property (@(posedge clk) disable iff (!en_rst_n)
        (sel_n && en_rst_n) |=> ($stable(byte_q) && $stable(bit_q) && $stable(done_q)));

    // R6
    // Once past the end, the position is frozen.
    end_freeze_chk: assert property (@(posedge clk) disable iff (!en_rst_n)
        (done_q && en_rst_n) |=> (done_q && $stable(byte_q) && $stable(bit_q)));

    // R9
    // The latched mode only moves on reset edges.
    mode_hold_chk: assert property (@(posedge clk) disable iff (!en_rst_n)
        en_rst_n |=> $stable(mode_q));
endmodule

// File: rtl/cfg_seq_drive.sv
// Module: output stage. Selects the serial bit or whole byte, forms the
// per-pin enables and the hand-off output with the chosen polarity.
// Assumes: inputs are the registered position from cfg_seq_counter.
module cfg_seq_drive
    import cfg_seq_pkg::*;
#(
    parameter bit HANDOFF_HIGH = 1'b0
) (
    input  logic                 clk,
    input  logic                 sel_n,
    input  logic                 en_rst_n,
    input  logic                 done_q,
    input  rd_mode_e             mode_q,
    input  logic [BIT_IDX_W-1:0] bit_q,
    input  logic [7:0]           cur_byte,
    output logic [7:0]           dq_o,
    output logic [7:0]           dq_oe,
    output logic                 handoff_o
);
    logic drive_en;
    logic handoff_act;
    logic ser_bit;

    // Purpose: qualify driving and hand-off from the controls and end flag.
    always_comb begin
        drive_en    = !sel_n && en_rst_n && !done_q;
        handoff_act = !sel_n && en_rst_n && done_q;
        ser_bit     = cur_byte[3'd7 - bit_q];
    end

    // Purpose: form pin values and enables for the latched width.
    always_comb begin
        dq_o  = '0;
        dq_oe = '0;
        if (drive_en) begin
            if (mode_q == RD_WIDE) begin
                dq_o  = cur_byte;
                dq_oe = '1;
            end else begin
                dq_o[0]  = ser_bit;
                dq_oe[0] = 1'b1;
            end
        end
    end

    // Purpose: apply the hand-off polarity chosen at elaboration.
    generate
        if (HANDOFF_HIGH) begin : g_ho_high
            assign handoff_o = handoff_act;
        end else begin : g_ho_low
            assign handoff_o = !handoff_act;
        end
    endgenerate

    // R4
    // Hand-off active implies select is asserted.
    handoff_sel_chk: assert property (@(posedge clk) disable iff (!en_rst_n)
        (handoff_o == HANDOFF_HIGH) |-> !sel_n);

    // R5
    // Reset forces hand-off inactive and pins released.
    reset_release_chk: assert property (@(posedge clk)
        !en_rst_n |-> (handoff_o != HANDOFF_HIGH && dq_oe == '0));

    // R7
    // Serial mode never enables more than pin 0.
    serial_pins_chk: assert property (@(posedge clk) disable iff (!en_rst_n)
        (mode_q == RD_SERIAL) |-> (dq_oe[7:1] == '0));

    // R6
    // Data pins and hand-off are never both active.
    no_overlap_chk: assert property (@(posedge clk) disable iff (!en_rst_n)
        !(dq_oe != '0 && handoff_o == HANDOFF_HIGH));
endmodule

// File: rtl/cfg_stream_seq.sv
// Module: top of the configuration stream sequencer. Ties the byte array,
// the position counter and the output stage together.
// Assumes: en_rst_n is held low for at least one edge before streaming.
module cfg_stream_seq
    import cfg_seq_pkg::*;
#(
    parameter int LAST_BYTE    = 15,
    parameter bit HANDOFF_HIGH = 1'b0,
    localparam int AW = (LAST_BYTE > 0) ? $clog2(LAST_BYTE + 1) : 1
) (
    input  logic          clk,
    input  logic          sel_n,
    input  logic          en_rst_n,
    input  logic          wide_i,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [7:0]    ld_data,
    output logic [7:0]    dq_o,
    output logic [7:0]    dq_oe,
    output logic          handoff_o
);
    logic [AW-1:0]        byte_q;
    logic [BIT_IDX_W-1:0] bit_q;
    logic                 done_q;
    rd_mode_e             mode_q;
    logic [7:0]           cur_byte;

    cfg_seq_store #(.AW(AW)) u_store (
        .clk     (clk),
        .wr_en   (ld_en),
        .wr_addr (ld_addr),
        .wr_data (ld_data),
        .rd_addr (byte_q),
        .rd_data (cur_byte)
    );

    cfg_seq_counter #(.AW(AW), .LAST_BYTE(LAST_BYTE)) u_cnt (
        .clk      (clk),
        .sel_n    (sel_n),
        .en_rst_n (en_rst_n),
        .wide_i   (wide_i),
        .byte_q   (byte_q),
        .bit_q    (bit_q),
        .done_q   (done_q),
        .mode_q   (mode_q)
    );

    cfg_seq_drive #(.HANDOFF_HIGH(HANDOFF_HIGH)) u_drv (
        .clk       (clk),
        .sel_n     (sel_n),
        .en_rst_n  (en_rst_n),
        .done_q    (done_q),
        .mode_q    (mode_q),
        .bit_q     (bit_q),
        .cur_byte  (cur_byte),
        .dq_o      (dq_o),
        .dq_oe     (dq_oe),
        .handoff_o (handoff_o)
    );

    // R1
    // Standby or reset never lets the hand-off appear from nothing.
    handoff_rise_chk: assert property (@(posedge clk) disable iff (!en_rst_n)
        (sel_n && handoff_o != HANDOFF_HIGH) |=> (sel_n || $stable(done_q)));
endmodule

// File: tb/tb_cfg_stream_seq.sv
module tb_cfg_stream_seq;
    localparam int LAST = 15;
    localparam int AW   = 4;

    logic          clk = 1'b0;
    logic          sel_n = 1'b1, en_rst_n = 1'b0, wide_i = 1'b0;
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [7:0]    ld_data = '0;
    logic [7:0]    dq_o, dq_oe, dq_o2, dq_oe2;
    logic          handoff_o, handoff2;

    int checks = 0;
    int errors = 0;

    // model state
    logic [7:0] img [LAST+1];
    int  m_byte = 0, m_bit = 0;
    bit  m_done = 1'b0, m_wide = 1'b0;

    always #2 clk = ~clk;

    cfg_stream_seq #(.LAST_BYTE(LAST), .HANDOFF_HIGH(1'b0)) dut (
        .clk(clk), .sel_n(sel_n), .en_rst_n(en_rst_n), .wide_i(wide_i),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .dq_o(dq_o), .dq_oe(dq_oe), .handoff_o(handoff_o));

    cfg_stream_seq #(.LAST_BYTE(LAST), .HANDOFF_HIGH(1'b1)) dut_hi (
        .clk(clk), .sel_n(sel_n), .en_rst_n(en_rst_n), .wide_i(wide_i),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .dq_o(dq_o2), .dq_oe(dq_oe2), .handoff_o(handoff2));

    function automatic string req_tag(bit s, bit e);
        if (!e)          return "R2 R5";
        if (s)           return "R3";
        if (m_done)      return "R4 R6";
        if (m_wide)      return "R8 R11";
        return "R7 R11";
    endfunction

    function automatic logic [7:0] exp_oe(bit s, bit e);
        if (s || !e || m_done) return 8'h00;
        return m_wide ? 8'hFF : 8'h01;
    endfunction

    function automatic logic [7:0] exp_dq(bit s, bit e);
        if (s || !e || m_done) return 8'h00;
        if (m_wide) return img[m_byte];
        return {7'b0, img[m_byte][7 - m_bit]};
    endfunction

    function automatic logic exp_ho(bit s, bit e);
        return !(!s && e && m_done);
    endfunction

    task automatic check_now();
        logic [7:0] eo, ed;
        logic eh;
        string t;
        eo = exp_oe(sel_n, en_rst_n);
        ed = exp_dq(sel_n, en_rst_n);
        eh = exp_ho(sel_n, en_rst_n);
        t  = req_tag(sel_n, en_rst_n);
        checks++;
        if (dq_oe !== eo || dq_o !== ed || handoff_o !== eh) begin
            errors++;
            $display("FAIL %s: oe=%h dq=%h ho=%b expected oe=%h dq=%h ho=%b",
                     t, dq_oe, dq_o, handoff_o, eo, ed, eh);
        end
        // R10: opposite polarity instance
        checks++;
        if (handoff2 !== !eh || dq_oe2 !== eo) begin
            errors++;
            $display("FAIL R10: ho_hi=%b oe=%h expected ho_hi=%b oe=%h",
                     handoff2, dq_oe2, !eh, eo);
        end
    endtask

    // drive one cycle: set inputs away from the edge, check, then model the edge
    task automatic cyc(bit s, bit e, bit w);
        @(negedge clk);
        sel_n = s; en_rst_n = e; wide_i = w;
        #1 check_now();
        @(posedge clk);
        if (!e) begin
            m_byte = 0; m_bit = 0; m_done = 1'b0; m_wide = w;   // R2 R9
        end else if (!s && !m_done) begin                        // R1
            if ((m_wide || m_bit == 7) && m_byte == LAST) m_done = 1'b1;
            else if (m_wide || m_bit == 7) begin m_byte++; m_bit = 0; end
            else m_bit++;
        end
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7131));
        // R11: load the array during reset
        for (int i = 0; i <= LAST; i++) begin
            @(negedge clk);
            img[i]  = 8'($urandom);
            ld_en   = 1'b1;
            ld_addr = AW'(i);
            ld_data = img[i];
        end
        @(negedge clk);
        ld_en = 1'b0;
        cyc(1, 0, 0);
        cyc(0, 0, 0);                       // reset state, serial latched

        // R7 serial stream with random standby gaps, past the end (R6)
        for (int n = 0; n < 200 && !m_done; n++)
            cyc(($urandom % 4) == 0, 1, $urandom % 2);  // R9 wide_i ignored
        for (int n = 0; n < 4; n++) cyc(0, 1, 1);       // R6 frozen
        // R4 hand-off follows select
        cyc(1, 1, 0); cyc(0, 1, 0); cyc(1, 1, 1); cyc(0, 1, 0);
        // R5 reset forces inactive, stays inactive after release
        cyc(0, 0, 1); cyc(1, 0, 1);
        // R8 wide mode run
        for (int n = 0; n < 40 && !m_done; n++) cyc(0, 1, 0);
        cyc(0, 1, 0); cyc(1, 1, 0);
        // reset in the middle of a stream
        cyc(0, 0, 0);
        for (int n = 0; n < 13; n++) cyc(0, 1, 1);
        cyc(0, 0, 1);
        for (int n = 0; n < 5; n++) cyc(0, 1, 0);
        // random mix
        for (int n = 0; n < 1500; n++)
            cyc(($urandom % 5) == 0, ($urandom % 60) != 0, $urandom % 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule